// File: doc/BRIEF.md
# Pipelined Complex Multiplier

This block multiplies two complex operands, each given as a signed two's-complement real and imaginary part. The A operand parts are `A_W` bits wide and the B operand parts are `B_W` bits wide. The exact product has `A_W+B_W+1` bits per component. A parameter picks which window of those bits comes out, and the window may reach above the exact width, in which case the output is sign-extended. When the window drops low-order bits, they are either truncated or rounded using a carry supplied alongside the operands.

A build parameter selects the arithmetic form: four real multiplies, or three real multiplies with pre-adders. Both forms give identical results. The pipeline has three enabled stages at its optimum (operand/pre-add, product, combine/round). Any extra latency requested is made up by register stages placed after the rounding stage. A clock enable freezes every stage. A synchronous clear zeroes every stage, and a parameter decides whether the clear acts on its own or only together with the enable.

Top module: `cplx_mult`

## Requirements
- R1: With the four-multiply form and the default window, `p_re` equals `a_re*b_re - a_im*b_im` and `p_im` equals `a_re*b_im + a_im*b_re`, each as an exact `A_W+B_W+1`-bit signed value.
- R2: With the three-multiply form (`ARCH = ARCH_THREE`), both outputs are bit-identical to the four-multiply form for every operand set.
- R3: The outputs carry bits `OUT_MSB` down to `OUT_LSB` of the (rounded) exact value. Bits above the exact width repeat its sign bit, and bits above `OUT_MSB` are dropped.
- R4: With `RND = RND_TRUNC` and `OUT_LSB > 0`, the low bits are discarded with no correction, which is a floor toward minus infinity.
- R5: With `RND = RND_CARRY` and `OUT_LSB > 0`, the value `2^(OUT_LSB-1) - 1 + rnd_carry` is added to the exact result before the low bits are dropped. `rnd_carry` is sampled on the same edge as the operands it goes with.
- R6: A result appears on the outputs after exactly `LATENCY` rising edges that have `clk_en` high, counted from the edge that captures its operands. `LATENCY` must be at least 3.
- R7: While `clk_en` is low and no clear acts, every stage and both outputs hold their values.
- R8: A clear zeroes every stage, so both outputs read 0 on the next edge. With `CLR_OVER_EN = 1` a high `sync_clr` clears on its own. With `CLR_OVER_EN = 0` it clears only on an edge where `clk_en` is also high.
- R9: Results stay exact for extreme operands, including the most negative value in every component at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clk_en | input | 1 | Active-high advance of every pipeline stage |
| sync_clr | input | 1 | Active-high synchronous clear of every stage |
| rnd_carry | input | 1 | Carry added at the rounding point, travels with the operands |
| a_re | input | A_W | Real part of operand A, signed |
| a_im | input | A_W | Imaginary part of operand A, signed |
| b_re | input | B_W | Real part of operand B, signed |
| b_im | input | B_W | Imaginary part of operand B, signed |
| p_re | output | OUT_MSB-OUT_LSB+1 | Selected window of the real product |
| p_im | output | OUT_MSB-OUT_LSB+1 | Selected window of the imaginary product |

## Verification
The embedded properties check on every cycle that a disabled enable freezes the outputs, that an acting clear leaves zeros one edge later, that each added delay stage moves its word forward by exactly one enabled edge, and that the three-multiply pre-add registers stay consistent with the captured operands. Numerical correctness of each form, the window and sign extension, truncation versus carry rounding, ties resolved in both directions by the carry, the exact latency count across stalled cycles, and the clear-versus-enable priority can only be shown by the bench. It does this by feeding the same stimulus to four differently configured instances and comparing each against an arithmetic reference.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic {
        ARCH_FOUR  = 1'b0,
        ARCH_THREE = 1'b1
    } arch_e;

    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_CARRY = 1'b1
    } rnd_e;

    // enabled edges needed by the arithmetic itself
    localparam int unsigned PIPE_OPT = 3;

    typedef struct packed {
        logic clr;
        logic en;
    } pipe_ctl_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmul_core.sv
module cmul_core
    import cmul_pkg::*;
#(
    parameter int unsigned A_W  = 16,
    parameter int unsigned B_W  = 16,
    parameter arch_e       ARCH = ARCH_FOUR,
    localparam int unsigned FW  = A_W + B_W + 1,
    localparam int unsigned PW  = A_W + B_W + 2
) (
    input  logic                  clk,
    input  pipe_ctl_t             ctl,
    input  logic signed [A_W-1:0] a_re,
    input  logic signed [A_W-1:0] a_im,
    input  logic signed [B_W-1:0] b_re,
    input  logic signed [B_W-1:0] b_im,
    input  logic                  cy,
    output logic signed [FW-1:0]  re_sum,
    output logic signed [FW-1:0]  im_sum,
    output logic                  cy_d
);

    logic [1:0] cy_q;

    always_ff @(posedge clk) begin
        if (ctl.clr)     cy_q <= '0;
        else if (ctl.en) cy_q <= {cy_q[0], cy};
    end
    assign cy_d = cy_q[1];

    generate
        if (ARCH == ARCH_THREE) begin : g_three
            logic signed [A_W-1:0] ar_q, ai_q;
            logic signed [B_W-1:0] br_q;
            logic signed [A_W:0]   sa_q;
            logic signed [B_W:0]   sb_q, db_q;
            logic signed [PW-1:0]  p0_q, p1_q, p2_q;

            always_ff @(posedge clk) begin
                if (ctl.clr) begin
                    ar_q <= '0; ai_q <= '0; br_q <= '0;
                    sa_q <= '0; sb_q <= '0; db_q <= '0;
                end else if (ctl.en) begin
                    ar_q <= a_re;
                    ai_q <= a_im;
                    br_q <= b_re;
                    sa_q <= (A_W+1)'(a_re) + (A_W+1)'(a_im);
                    sb_q <= (B_W+1)'(b_re) + (B_W+1)'(b_im);
                    db_q <= (B_W+1)'(b_im) - (B_W+1)'(b_re);
                end
            end

            always_ff @(posedge clk) begin
                if (ctl.clr) begin
                    p0_q <= '0; p1_q <= '0; p2_q <= '0;
                end else if (ctl.en) begin
                    p0_q <= PW'(br_q) * PW'(sa_q);
                    p1_q <= PW'(ai_q) * PW'(sb_q);
                    p2_q <= PW'(ar_q) * PW'(db_q);
                end
            end

            assign re_sum = FW'(p0_q - p1_q);
            assign im_sum = FW'(p0_q + p2_q);

            // R2
            three_preadd_chk: assert property (@(posedge clk) disable iff (ctl.clr)
                sa_q == (A_W+1)'(ar_q) + (A_W+1)'(ai_q));
        end else begin : g_four
            logic signed [A_W-1:0] ar_q, ai_q;
            logic signed [B_W-1:0] br_q, bi_q;
            logic signed [PW-1:0]  p0_q, p1_q, p2_q, p3_q;

            always_ff @(posedge clk) begin
                if (ctl.clr) begin
                    ar_q <= '0; ai_q <= '0; br_q <= '0; bi_q <= '0;
                end else if (ctl.en) begin
                    ar_q <= a_re; ai_q <= a_im; br_q <= b_re; bi_q <= b_im;
                end
            end

            always_ff @(posedge clk) begin
                if (ctl.clr) begin
                    p0_q <= '0; p1_q <= '0; p2_q <= '0; p3_q <= '0;
                end else if (ctl.en) begin
                    p0_q <= PW'(ar_q) * PW'(br_q);
                    p1_q <= PW'(ai_q) * PW'(bi_q);
                    p2_q <= PW'(ar_q) * PW'(bi_q);
                    p3_q <= PW'(ai_q) * PW'(br_q);
                end
            end

            assign re_sum = FW'(p0_q - p1_q);
            assign im_sum = FW'(p2_q + p3_q);
        end
    endgenerate

endmodule

// File: rtl/cmul_round.sv
module cmul_round
    import cmul_pkg::*;
#(
    parameter int unsigned FW      = 33,
    parameter int unsigned OUT_MSB = 32,
    parameter int unsigned OUT_LSB = 0,
    parameter rnd_e        RND     = RND_TRUNC,
    localparam int unsigned OW     = OUT_MSB - OUT_LSB + 1,
    localparam int unsigned EW     = imax(FW, OUT_MSB + 1) + 1
) (
    input  logic signed [FW-1:0] x,
    input  logic                 cy,
    output logic [OW-1:0]        y
);

    logic signed [EW-1:0] xe, bias, tot;
    logic                 unused_tot;

    assign xe = EW'(x);

    generate
        if (RND == RND_CARRY && OUT_LSB > 0) begin : g_carry
            localparam logic [EW-1:0] HALF_M1 = (EW'(1) << (OUT_LSB - 1)) - EW'(1);
            assign bias = $signed(HALF_M1 + {{(EW-1){1'b0}}, cy});
        end else begin : g_plain
            logic unused_cy;
            assign unused_cy = cy;
            assign bias = '0;
        end
    endgenerate

    assign tot        = xe + bias;
    assign y          = tot[OUT_MSB:OUT_LSB];
    assign unused_tot = ^tot;

endmodule

// File: rtl/cmul_delay.sv
module cmul_delay
    import cmul_pkg::*;
#(
    parameter int unsigned W     = 66,
    parameter int unsigned DEPTH = 0
) (
    input  logic         clk,
    input  pipe_ctl_t    ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_pass
            logic unused_pass;
            assign unused_pass = ^{clk, ctl};
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] st [DEPTH];
            for (genvar i = 0; i < int'(DEPTH); i++) begin : g_st
                if (i == 0) begin : g_head
                    always_ff @(posedge clk) begin
                        if (ctl.clr)     st[0] <= '0;
                        else if (ctl.en) st[0] <= d;
                    end
                end else begin : g_tail
                    always_ff @(posedge clk) begin
                        if (ctl.clr)     st[i] <= '0;
                        else if (ctl.en) st[i] <= st[i-1];
                    end
                    // R6
                    hop_chk: assert property (@(posedge clk) disable iff (ctl.clr)
                        ctl.en |=> st[i] == $past(st[i-1]));
                end
            end
            assign q = st[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cplx_mult.sv
module cplx_mult
    import cmul_pkg::*;
#(
    parameter int unsigned A_W         = 16,
    parameter int unsigned B_W         = 16,
    parameter arch_e       ARCH        = ARCH_FOUR,
    parameter int unsigned OUT_MSB     = A_W + B_W,
    parameter int unsigned OUT_LSB     = 0,
    parameter rnd_e        RND         = RND_TRUNC,
    parameter bit          CLR_OVER_EN = 1'b1,
    parameter int unsigned LATENCY     = PIPE_OPT,
    localparam int unsigned FW         = A_W + B_W + 1,
    localparam int unsigned OW         = OUT_MSB - OUT_LSB + 1,
    localparam int unsigned PAD        = LATENCY - PIPE_OPT
) (
    input  logic                  clk,
    input  logic                  clk_en,
    input  logic                  sync_clr,
    input  logic                  rnd_carry,
    input  logic signed [A_W-1:0] a_re,
    input  logic signed [A_W-1:0] a_im,
    input  logic signed [B_W-1:0] b_re,
    input  logic signed [B_W-1:0] b_im,
    output logic [OW-1:0]         p_re,
    output logic [OW-1:0]         p_im
);

    pipe_ctl_t            ctl;
    logic signed [FW-1:0] re_sum, im_sum;
    logic                 cy_d;
    logic [OW-1:0]        re_rnd, im_rnd;
    logic [OW-1:0]        re_q, im_q;

    assign ctl.en  = clk_en;
    assign ctl.clr = sync_clr & (CLR_OVER_EN | clk_en);

    cmul_core #(.A_W(A_W), .B_W(B_W), .ARCH(ARCH)) u_core (
        .clk(clk), .ctl(ctl),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .cy(rnd_carry), .re_sum(re_sum), .im_sum(im_sum), .cy_d(cy_d)
    );

    cmul_round #(.FW(FW), .OUT_MSB(OUT_MSB), .OUT_LSB(OUT_LSB), .RND(RND)) u_rnd_re (
        .x(re_sum), .cy(cy_d), .y(re_rnd)
    );

    cmul_round #(.FW(FW), .OUT_MSB(OUT_MSB), .OUT_LSB(OUT_LSB), .RND(RND)) u_rnd_im (
        .x(im_sum), .cy(cy_d), .y(im_rnd)
    );

    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            re_q <= '0;
            im_q <= '0;
        end else if (ctl.en) begin
            re_q <= re_rnd;
            im_q <= im_rnd;
        end
    end

    cmul_delay #(.W(2*OW), .DEPTH(PAD)) u_pad (
        .clk(clk), .ctl(ctl), .d({re_q, im_q}), .q({p_re, p_im})
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (sync_clr)
        !clk_en |=> ($stable(p_re) && $stable(p_im)));

    // R8
    clear_zero_chk: assert property (@(posedge clk)
        (sync_clr && (CLR_OVER_EN || clk_en)) |=> (p_re == '0 && p_im == '0));

endmodule

// File: tb/tb_cplx_mult.sv
module tb_cplx_mult;
    import cmul_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int QCAP = 8;

    typedef struct {
        logic signed [15:0] ar, ai, br, bi;
        logic               cy;
    } item_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic clk_en, sync_clr, rnd_carry;
    logic signed [15:0] a_re, a_im, b_re, b_im;
    logic [32:0] p_re_0, p_im_0, p_re_1, p_im_1;
    logic [27:0] p_re_2, p_im_2;
    logic [24:0] p_re_3, p_im_3;

    int n_tests = 0;
    int n_fail = 0;
    bit sb_on = 1'b1;
    item_t q[$];

    // default: four multiplies, full window, latency 3
    cplx_mult dut (
        .clk(clk), .clk_en(clk_en), .sync_clr(sync_clr), .rnd_carry(rnd_carry),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .p_re(p_re_0), .p_im(p_im_0));

    cplx_mult #(.ARCH(ARCH_THREE), .LATENCY(5)) u_three (
        .clk(clk), .clk_en(clk_en), .sync_clr(sync_clr), .rnd_carry(rnd_carry),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .p_re(p_re_1), .p_im(p_im_1));

    cplx_mult #(.OUT_MSB(35), .OUT_LSB(8), .RND(RND_TRUNC), .LATENCY(4)) u_trunc (
        .clk(clk), .clk_en(clk_en), .sync_clr(sync_clr), .rnd_carry(rnd_carry),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .p_re(p_re_2), .p_im(p_im_2));

    cplx_mult #(.ARCH(ARCH_THREE), .OUT_MSB(30), .OUT_LSB(6), .RND(RND_CARRY),
                .CLR_OVER_EN(1'b0), .LATENCY(3)) u_carry (
        .clk(clk), .clk_en(clk_en), .sync_clr(sync_clr), .rnd_carry(rnd_carry),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .p_re(p_re_3), .p_im(p_im_3));

    function automatic longint ref_re(input item_t t);
        return longint'(t.ar) * longint'(t.br) - longint'(t.ai) * longint'(t.bi);
    endfunction

    function automatic longint ref_im(input item_t t);
        return longint'(t.ar) * longint'(t.bi) + longint'(t.ai) * longint'(t.br);
    endfunction

    function automatic logic [63:0] win(input longint x, input int msb, input int lsb,
                                        input bit rnd, input logic cy);
        longint v;
        v = x;
        if (rnd && lsb > 0) v = v + (longint'(1) << (lsb - 1)) - 1 + longint'(cy);
        v = v >>> lsb;
        return 64'(v) & ((64'd1 << (msb - lsb + 1)) - 64'd1);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic item_t zero_item();
        item_t z;
        z.ar = '0; z.ai = '0; z.br = '0; z.bi = '0; z.cy = 1'b0;
        return z;
    endfunction

    // scoreboard push side: one entry per enabled edge
    always @(posedge clk) begin
        if (sb_on) begin
            if (sync_clr && clk_en) begin
                q.delete();
                for (int i = 0; i < QCAP; i++) q.push_back(zero_item());
            end else if (clk_en) begin
                item_t t;
                t.ar = a_re; t.ai = a_im; t.br = b_re; t.bi = b_im; t.cy = rnd_carry;
                q.push_back(t);
                if (q.size() > QCAP) void'(q.pop_front());
            end
        end
    end

    // scoreboard compare side, away from the active edge
    always @(negedge clk) begin
        if (sb_on && q.size() >= 5) begin
            item_t t0, t1, t2, t3;
            t0 = q[q.size()-3];
            t1 = q[q.size()-5];
            t2 = q[q.size()-4];
            t3 = q[q.size()-3];
            check("R1 R6 R9 four-mult real", 64'(p_re_0), win(ref_re(t0), 32, 0, 0, 1'b0));
            check("R1 R6 R9 four-mult imag", 64'(p_im_0), win(ref_im(t0), 32, 0, 0, 1'b0));
            check("R2 R6 R9 three-mult real", 64'(p_re_1), win(ref_re(t1), 32, 0, 0, 1'b0));
            check("R2 R6 R9 three-mult imag", 64'(p_im_1), win(ref_im(t1), 32, 0, 0, 1'b0));
            check("R3 R4 sign-ext trunc real", 64'(p_re_2), win(ref_re(t2), 35, 8, 0, 1'b0));
            check("R3 R4 sign-ext trunc imag", 64'(p_im_2), win(ref_im(t2), 35, 8, 0, 1'b0));
            check("R5 R3 carry round real", 64'(p_re_3), win(ref_re(t3), 30, 6, 1, t3.cy));
            check("R5 R3 carry round imag", 64'(p_im_3), win(ref_im(t3), 30, 6, 1, t3.cy));
        end
    end

    task automatic drive(input int ar, input int ai, input int br, input int bi,
                         input logic cy, input logic en);
        @(negedge clk);
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
        rnd_carry = cy; clk_en = en; sync_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [24:0] held_re, held_im;
        clk_en = 1'b1; sync_clr = 1'b1; rnd_carry = 1'b0;
        a_re = '0; a_im = '0; b_re = '0; b_im = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset real", 64'(p_re_0), 64'd0);
        check("R8 reset imag", 64'(p_im_1), 64'd0);

        // extreme and sign corner patterns (R9)
        drive(0, 0, 0, 0, 1'b0, 1'b1);
        drive(32767, 32767, 32767, 32767, 1'b1, 1'b1);
        drive(-32768, -32768, -32768, -32768, 1'b0, 1'b1);
        drive(-32768, -32768, -32768, -32768, 1'b1, 1'b1);
        drive(-32768, 32767, -32768, 32767, 1'b0, 1'b1);
        drive(32767, -32768, 32767, -32768, 1'b1, 1'b1);
        drive(0, -32768, 0, -32768, 1'b0, 1'b1);
        // rounding ties at bit 5 (R5): +32 and -32 with both carries
        drive(32, 0, 1, 0, 1'b0, 1'b1);
        drive(32, 0, 1, 0, 1'b1, 1'b1);
        drive(-32, 0, 1, 0, 1'b0, 1'b1);
        drive(-32, 0, 1, 0, 1'b1, 1'b1);
        // truncation of small negatives (R4)
        drive(-1, 0, 1, 0, 1'b0, 1'b1);
        drive(-255, 0, 1, 0, 1'b0, 1'b1);
        drive(256, 0, -1, 0, 1'b0, 1'b1);

        // random traffic with stalls (R6, R7)
        for (int k = 0; k < 600; k++) begin
            drive($urandom, $urandom, $urandom, $urandom, 1'($urandom),
                  1'(($urandom % 4) != 0));
        end

        // fill every stage with one nonzero item
        repeat (QCAP) drive(1000, 2000, -3000, 4000, 1'b1, 1'b1);

        // clear while enable is low: priority differs per instance (R8)
        held_re = p_re_3;
        held_im = p_im_3;
        @(negedge clk);
        clk_en = 1'b0; sync_clr = 1'b1;
        #1 sb_on = 1'b0;
        @(negedge clk);
        check("R8 clear wins over low enable", 64'(p_re_0), 64'd0);
        check("R8 clear wins over low enable 3m", 64'(p_im_1), 64'd0);
        check("R8 clear needs enable, real held", 64'(p_re_3), 64'(held_re));
        check("R8 clear needs enable, imag held", 64'(p_im_3), 64'(held_im));
        check("R8 clear needs enable, nonzero", 64'(p_re_3 != '0), 64'd1);
        clk_en = 1'b1; sync_clr = 1'b1;
        #1 sb_on = 1'b1;
        @(negedge clk);
        check("R8 clear with enable", 64'(p_re_3), 64'd0);

        for (int k = 0; k < 40; k++) begin
            drive($urandom, $urandom, $urandom, $urandom, 1'($urandom), 1'b1);
        end
        repeat (6) drive(0, 0, 0, 0, 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule